// File: doc/BRIEF.md
# Register File with Stored Branch-Against-Zero Conditions

This block is a multi-ported register file for a processor core. Next to every data word it keeps a small condition tag that is computed from the value at the moment the value is written. A branch that compares one register with zero does not scan all data bits when it resolves. It picks a single condition out of the tag that is already stored. The data array serves the two operand read ports. The tag array sits in a separate bank and serves only the branch port.

Each write updates the data word and its tag at the same clock edge, so the data path gains no extra latency. A parameter chooses how the tag is stored. In the wide form there is one bit for each condition, and the branch port only selects a bit. In the compact form the tag is two bits, sign and zero, and a small decoder follows the select. If a write and a branch lookup target the same register in the same cycle, the branch port sees the tag of the value being written. Register 0 always holds zero.

Top module: `brtag_regfile`

## Requirements
- R1: After reset every register reads as zero on both read ports, and the branch port treats every register as holding zero.
- R2: A write with `wrEn` high to a register other than 0 is visible on `rdDataA` and `rdDataB` from the cycle after the clock edge that accepts it. A read of that register in the cycle of the write still returns the previous value.
- R3: Register 0 always reads as zero. Writes addressed to it have no effect.
- R4: `brTaken` reports the condition selected by `brCond` for the signed two's-complement value held in register `brAddr`. The codes are: 0 equal to zero, 1 not zero, 2 less than or equal to zero, 3 greater than zero, 4 less than zero, 5 greater than or equal to zero.
- R5: `brCond` codes 6 and 7 never report taken.
- R6: The tag is stored at the same edge as the data. In the first cycle after a write, the branch port already reflects the new value.
- R7: If `wrEn` is high, `wrAddr` equals `brAddr` and the address is not 0, then `brTaken` is computed from `wrData` in that same cycle.
- R8: For register 0 the branch port reports equal-to-zero, less-or-equal-to-zero and greater-or-equal-to-zero as taken, and the other three conditions as not taken.
- R9: The compact two-bit tag (`ENCODED`=1, stored as {sign, zero}) and the six-bit tag (`ENCODED`=0, bit i set when condition code i holds) give identical `brTaken` for every register contents and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Register written |
| wrData | input | DATA_W | Value written |
| rdAddrA | input | ADDR_W | Operand A register |
| rdDataA | output | DATA_W | Operand A value |
| rdAddrB | input | ADDR_W | Operand B register |
| rdDataB | output | DATA_W | Operand B value |
| brAddr | input | ADDR_W | Register tested by the branch |
| brCond | input | 3 | Condition code to test |
| brTaken | output | 1 | Selected condition holds |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume that `NUM_REGS` is a power of two, so every address names a real register. With those inputs, a property that looks one cycle back at a write can rely on the register holding exactly the written word. The bench drives all inputs from time zero and changes them only at falling edges, away from the sampling edge. It uses only addresses inside the 16-entry file. It runs the compact and the wide variant side by side on the same inputs.

// File: rtl/brtag_pkg.sv
package brtag_pkg;

  typedef enum logic [2:0] {
    CondEqz  = 3'd0,
    CondNez  = 3'd1,
    CondLez  = 3'd2,
    CondGtz  = 3'd3,
    CondLtz  = 3'd4,
    CondGez  = 3'd5,
    CondRsv6 = 3'd6,
    CondRsv7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic commitWrite;  // write lands in a real register this cycle
    logic tagBypass;    // branch port must take the tag being written
  } strobe_t;

  // Wide tag: bit index equals the condition code.
  function automatic logic [5:0] wideTag(input logic isNeg, input logic isZero);
    wideTag = {~isNeg, isNeg, ~isNeg & ~isZero, isNeg | isZero, ~isZero, isZero};
  endfunction

endpackage

// File: rtl/brtag_ctrl.sv
module brtag_ctrl
  import brtag_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] brAddr,
  output strobe_t           strobes
);

  always_comb begin
    strobes.commitWrite = wrEn && (wrAddr != '0);
    strobes.tagBypass   = strobes.commitWrite && (wrAddr == brAddr);
  end

endmodule

// File: rtl/brtag_tagbank.sv
module brtag_tagbank
  import brtag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter bit ENCODED  = 1'b1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [2:0]        brCond,
  output logic              brTaken
);

  logic newNeg, newZero;
  assign newNeg  = wrData[DATA_W-1];
  assign newZero = (wrData == '0);

  if (ENCODED) begin : gCompact
    logic [1:0] tagMem [NUM_REGS];
    logic [1:0] curTag, selTag;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_REGS; i++) tagMem[i] <= 2'b01;
      end else if (strobes.commitWrite) begin
        tagMem[wrAddr] <= {newNeg, newZero};
      end
    end

    assign curTag = (brAddr == '0) ? 2'b01 : tagMem[brAddr];
    assign selTag = strobes.tagBypass ? {newNeg, newZero} : curTag;

    always_comb begin
      unique case (cond_e'(brCond))
        CondEqz: brTaken = selTag[0];
        CondNez: brTaken = ~selTag[0];
        CondLez: brTaken = selTag[1] | selTag[0];
        CondGtz: brTaken = ~selTag[1] & ~selTag[0];
        CondLtz: brTaken = selTag[1];
        CondGez: brTaken = ~selTag[1];
        default: brTaken = 1'b0;
      endcase
    end
  end else begin : gWide
    localparam logic [5:0] ZERO_TAG = wideTag(1'b0, 1'b1);
    logic [5:0] tagMem [NUM_REGS];
    logic [5:0] curTag, selTag;
    logic [7:0] padTag;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_REGS; i++) tagMem[i] <= ZERO_TAG;
      end else if (strobes.commitWrite) begin
        tagMem[wrAddr] <= wideTag(newNeg, newZero);
      end
    end

    assign curTag  = (brAddr == '0) ? ZERO_TAG : tagMem[brAddr];
    assign selTag  = strobes.tagBypass ? wideTag(newNeg, newZero) : curTag;
    assign padTag  = {2'b00, selTag};
    assign brTaken = padTag[brCond];
  end

endmodule

// File: rtl/brtag_dp.sv
module brtag_dp
  import brtag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter bit ENCODED  = 1'b1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [2:0]        brCond,
  output logic              brTaken
);

  logic [DATA_W-1:0] regWord [NUM_REGS];

  assign regWord[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regWord[g] <= '0;
      else if (strobes.commitWrite && (wrAddr == ADDR_W'(g))) regWord[g] <= wrData;
    end
  end

  assign rdDataA = regWord[rdAddrA];
  assign rdDataB = regWord[rdAddrB];

  brtag_tagbank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ENCODED(ENCODED)
  ) tagBank (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .wrData(wrData),
    .brAddr(brAddr), .brCond(brCond), .brTaken(brTaken)
  );

endmodule

// File: rtl/brtag_regfile.sv
module brtag_regfile
  import brtag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter bit ENCODED  = 1'b1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [2:0]        brCond,
  output logic              brTaken
);

  strobe_t strobes;

  brtag_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .brAddr(brAddr), .strobes(strobes)
  );

  brtag_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ENCODED(ENCODED)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .brAddr(brAddr), .brCond(brCond), .brTaken(brTaken)
  );

endmodule

// File: rtl/brtag_checker.sv
module brtag_checker
  import brtag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic [ADDR_W-1:0] brAddr,
  input logic [2:0]        brCond,
  input logic              brTaken
);

  assert_zero_reg_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0));

  assert_zero_reg_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == '0) |-> (rdDataB == '0));

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=> ((rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData))));

  assert_tag_no_delay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=>
      ((brAddr != $past(wrAddr)) || (wrEn && wrAddr == brAddr) || (brCond != CondEqz) ||
       (brTaken == ($past(wrData) == '0))));

  assert_reserved_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (brCond == CondRsv6 || brCond == CondRsv7) |-> !brTaken);

  assert_reg0_nonneg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (brAddr == '0 && brCond == CondGez) |-> brTaken);

  assert_same_cycle_tag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && wrAddr == brAddr && brCond == CondLtz) |->
      (brTaken == wrData[DATA_W-1]));

endmodule

bind brtag_regfile brtag_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk (.*);

// File: tb/brtag_regfile_test.sv
module brtag_regfile_test;

  localparam int DW = 32;
  localparam int NR = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddrA = '0, rdAddrB = '0, brAddr = '0;
  logic [2:0]    brCond = '0;
  logic [DW-1:0] rdDataA, rdDataB, rawRdA, rawRdB;
  logic          brTaken, rawTaken;

  int testCount = 0;
  int failCount = 0;
  logic [DW-1:0] model [NR];

  always #2 clk = ~clk;

  brtag_regfile #(.DATA_W(DW), .NUM_REGS(NR), .ENCODED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .brAddr(brAddr), .brCond(brCond), .brTaken(brTaken));

  brtag_regfile #(.DATA_W(DW), .NUM_REGS(NR), .ENCODED(1'b0)) uutRaw (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rawRdA), .rdAddrB(rdAddrB), .rdDataB(rawRdB),
    .brAddr(brAddr), .brCond(brCond), .brTaken(rawTaken));

  function automatic logic expTaken(input logic [DW-1:0] v, input int c);
    case (c)
      0: return v == '0;
      1: return v != '0;
      2: return $signed(v) <= 0;
      3: return $signed(v) > 0;
      4: return $signed(v) < 0;
      5: return $signed(v) >= 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkEq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a != '0) model[a] = d;
  endtask

  task automatic checkRead(input string req, input logic [AW-1:0] a);
    rdAddrA = a; rdAddrB = a;
    @(negedge clk);
    checkEq(req, rdDataA, model[a]);
    checkEq(req, rdDataB, model[a]);
    checkEq({req, " wide"}, rawRdA, model[a]);
  endtask

  // Every code on one register; wide and compact variants compared (R9).
  task automatic probeBranches(input string req, input logic [AW-1:0] a);
    for (int c = 0; c < 8; c++) begin
      brAddr = a; brCond = 3'(c);
      @(negedge clk);
      checkEq((c >= 6) ? "R5" : req, 32'(brTaken), 32'(expTaken(model[a], c)));
      checkEq("R9", 32'(rawTaken), 32'(brTaken));
    end
  endtask

  task automatic testReset();
    for (int r = 0; r < NR; r++) checkRead("R1", AW'(r));
    probeBranches("R1", 4'd9);
    probeBranches("R8", 4'd0);
  endtask

  task automatic testWriteRead();
    doWrite(4'd1, 32'd5);
    doWrite(4'd2, 32'hFFFF_FFFF);
    doWrite(4'd3, 32'h8000_0000);
    doWrite(4'd4, 32'h7FFF_FFFF);
    doWrite(4'd5, 32'd0);
    for (int r = 1; r <= 5; r++) begin
      checkRead("R2", AW'(r));
      probeBranches("R4", AW'(r));
    end
  endtask

  task automatic testReg0();
    doWrite(4'd0, 32'hDEAD_BEEF);
    checkRead("R3", 4'd0);
    probeBranches("R8", 4'd0);
  endtask

  task automatic testBypassAndLatency();
    doWrite(4'd7, 32'd3);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd7; wrData = 32'h8000_0000;
    brAddr = 4'd7; brCond = 3'd4; rdAddrA = 4'd7;
    #1;
    checkEq("R7", 32'(brTaken), 32'd1);
    checkEq("R7", 32'(rawTaken), 32'd1);
    checkEq("R2 old value", rdDataA, 32'd3);
    @(negedge clk);
    wrEn = 1'b0; model[7] = 32'h8000_0000;
    #1;
    checkEq("R6", 32'(brTaken), 32'd1);
    checkEq("R2", rdDataA, 32'h8000_0000);
    // No bypass when the branch looks at another register.
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd8; wrData = 32'd0; brAddr = 4'd7; brCond = 3'd0;
    #1;
    checkEq("R7 other reg", 32'(brTaken), 32'd0);
    @(negedge clk);
    wrEn = 1'b0; model[8] = 32'd0;
    brAddr = 4'd8; brCond = 3'd0;
    #1;
    checkEq("R6", 32'(brTaken), 32'd1);
  endtask

  task automatic testSweep();
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, NR - 1));
      case (n % 4)
        0: d = 32'd0;
        1: d = 32'($urandom_range(1, 1000));
        2: d = -32'($urandom_range(1, 1000));
        default: d = $urandom();
      endcase
      doWrite(a, d);
      probeBranches("R4", a);
      checkRead(a == '0 ? "R3" : "R2", a);
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteRead();
    testReg0();
    testBypassAndLatency();
    testSweep();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule